// File: doc/BRIEF.md
# EEPROM Write-Busy Status Readback

This block sits in the read-data path of a byte-wide parallel EEPROM model. When the host writes a byte, the block latches that byte and starts an internal write timer. While the timer runs, the block raises a busy flag, and every read returns a status word instead of array contents. In that word, bit 7 is the inverse of bit 7 of the latched byte. Bit 6 flips on each successive read. Bits 5..0 repeat the latched byte.

A host can finish a write in either of two ways. It can read until bit 7 matches what it wrote, or it can read until bit 6 stops changing. Once the timer expires, reads return the stored data from the array input unchanged. A write strobe raised while the timer is running is dropped.

Top module: `eeprom_busy_readback`

## Requirements
- R1: After reset, `busy` is 0 and `rdData` is 8'h00.
- R2: A write strobe seen while `busy` is 0 is accepted. `busy` goes to 1 on the clock edge after the strobe and stays 1 for exactly WR_CYCLES clock cycles.
- R3: A write strobe seen while `busy` is 1 is ignored. The latched byte seen in later status reads stays the same, and the busy period is not lengthened.
- R4: A read strobe while busy updates `rdData`, one cycle later, so that bit 7 is the inverse of bit 7 of the latched byte.
- R5: During busy, bit 6 of the status word is 0 on the first read after a write is accepted, then flips on each further read strobe. Clock cycles with no read strobe do not flip it.
- R6: During busy, bits 5..0 of the status word equal bits 5..0 of the latched byte.
- R7: A read strobe while not busy updates `rdData`, one cycle later, to the value of `arrayData`.
- R8: Accepting a new write returns the bit-6 toggle to 0, whatever its value was before.
- R9: When a read strobe comes in the same cycle as an accepted write, the read returns `arrayData`, because busy has not yet risen. The toggle is still cleared, so the first busy read shows bit 6 = 0.
- R10: `rdData` holds its value in any cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Host write strobe, one cycle per byte |
| wrData | input | 8 | Byte being written |
| rdStb | input | 1 | Host read strobe |
| arrayData | input | 8 | Stored data from the memory array |
| rdData | output | 8 | Registered read result |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two things can happen in the same cycle: a read and the acceptance of a write. The bench raises both strobes together while the block is idle. It then expects array data for that read, busy high on the next cycle, and bit 6 equal to 0 on the first busy read that follows. A write attempt in the middle of a busy period is also combined with status reads, and the bench judges it by the byte reflected in later reads and by the total count of busy cycles.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  typedef struct packed {
    logic accept;    // write taken this cycle
    logic busyRead;  // read strobe during busy period
    logic idleRead;  // read strobe while idle
  } ebr_strobe_t;
endpackage

// File: rtl/ebr_ctrl.sv
module ebr_ctrl
  import ebr_pkg::*;
#(
  parameter int WR_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStb,
  input  logic        rdStb,
  output logic        busy,
  output ebr_strobe_t stb
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

  logic [CW-1:0] remain;
  logic          accept;

  assign busy   = (remain != '0);
  assign accept = wrStb && !busy;

  always_comb begin
    stb          = '0;
    stb.accept   = accept;
    stb.busyRead = rdStb && busy;
    stb.idleRead = rdStb && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             remain <= '0;
    else if (accept)       remain <= LOAD;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrStb));
  // R3
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrStb) |=> (remain == $past(remain) - 1'b1));
  // R2
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    remain <= LOAD);
endmodule

// File: rtl/ebr_dpath.sv
module ebr_dpath
  import ebr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ebr_strobe_t   stb,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic [DW-1:0] lastByte;
  logic          togQ;
  logic [DW-1:0] statusWord;

  always_comb begin
    statusWord           = lastByte;
    statusWord[POLL_BIT] = ~lastByte[POLL_BIT];
    statusWord[TOG_BIT]  = togQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastByte <= '0;
      togQ     <= 1'b0;
      rdData   <= '0;
    end else begin
      if (stb.accept) lastByte <= wrData;
      if (stb.accept)        togQ <= 1'b0;
      else if (stb.busyRead) togQ <= ~togQ;
      if (stb.busyRead)      rdData <= statusWord;
      else if (stb.idleRead) rdData <= arrayData;
    end
  end

  // R4
  poll_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.busyRead |=> (rdData[POLL_BIT] != lastByte[POLL_BIT]));
  // R7
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.idleRead |=> (rdData == $past(arrayData)));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.busyRead || stb.idleRead) |=> $stable(rdData));
  // R8
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.accept |=> !togQ);
endmodule

// File: rtl/eeprom_busy_readback.sv
module eeprom_busy_readback
  import ebr_pkg::*;
#(
  parameter int WR_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  input  logic       rdStb,
  input  logic [7:0] arrayData,
  output logic [7:0] rdData,
  output logic       busy
);
  ebr_strobe_t stb;

  ebr_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb),
    .busy(busy), .stb(stb)
  );

  ebr_dpath #(.DW(8)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .arrayData(arrayData), .rdData(rdData)
  );
endmodule

// File: tb/eeprom_busy_readback_bench.sv
module eeprom_busy_readback_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 16;
  localparam logic [7:0] VEC_W[4] = '{8'h80, 8'h3F, 8'hC5, 8'h5A};
  localparam logic [7:0] VEC_A[4] = '{8'h11, 8'hEE, 8'h7C, 8'h00};

  logic clk = 0, rstN = 0, wrStb = 0, rdStb = 0;
  logic [7:0] wrData = 0, arrayData = 0, rdData;
  logic busy;
  int total = 0, bad = 0;
  logic tog;
  int n;

  eeprom_busy_readback #(.WR_CYCLES(WRC)) u_eeprom_busy_readback (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb),
    .arrayData(arrayData), .rdData(rdData), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic [7:0] w, input logic t);
    return {~w[7], t, w[5:0]};
  endfunction

  task automatic doWrite(input logic [7:0] d);
    wrData = d; wrStb = 1;
    @(negedge clk); wrStb = 0;
  endtask

  task automatic doRead();
    rdStb = 1;
    @(negedge clk); rdStb = 0;
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {7'd0, busy}, 8'h00);
    chk("R1 rdData", rdData, 8'h00);
    rstN = 1;
    @(negedge clk);

    // vector table walk: R2 R4 R5 R6 R7
    for (int i = 0; i < 4; i++) begin
      arrayData = VEC_A[i];
      doWrite(VEC_W[i]);
      chk("R2 busy rises", {7'd0, busy}, 8'h01);
      tog = 0;
      for (int k = 0; k < 3; k++) begin
        doRead();
        chk("R4/R5/R6 status", rdData, stat(VEC_W[i], tog));
        tog = ~tog;
      end
      drain();
      doRead();
      chk("R7 idle read", rdData, VEC_A[i]);
    end

    // R2 + R3: ignored write mid-busy, busy length exact
    arrayData = 8'hA5;
    doWrite(8'h41);
    n = busy ? 1 : 0;
    doWrite(8'hBE);               // ignored
    if (busy) n++;
    doRead();
    if (busy) n++;
    chk("R3 latched byte kept", rdData, stat(8'h41, 1'b0));
    while (busy) begin @(negedge clk); if (busy) n++; end
    chk("R2/R3 busy length", 8'(n), 8'(WRC));

    // R5 toggle ignores clock, R10 hold
    doWrite(8'h07);
    doRead();
    chk("R5 first", rdData, stat(8'h07, 1'b0));
    repeat (3) @(negedge clk);
    chk("R10 hold", rdData, stat(8'h07, 1'b0));
    doRead();
    chk("R5 after gap", rdData, stat(8'h07, 1'b1));
    doRead();              // toggle now at 1
    chk("R5 third", rdData, stat(8'h07, 1'b0));
    drain();

    // R8: odd count left toggle at 1; new write clears it
    doWrite(8'hF0);
    doRead();
    chk("R8 toggle cleared", rdData, stat(8'hF0, 1'b0));
    doRead();              // toggle -> 0 after this? it reads 1
    chk("R5 flip", rdData, stat(8'hF0, 1'b1));
    doRead();
    drain();

    // R9: read and write in the same cycle
    arrayData = 8'h3C;
    wrData = 8'h92; wrStb = 1; rdStb = 1;
    @(negedge clk); wrStb = 0; rdStb = 0;
    chk("R9 same-cycle read", rdData, 8'h3C);
    chk("R9 busy", {7'd0, busy}, 8'h01);
    doRead();
    chk("R9 first busy read", rdData, stat(8'h92, 1'b0));
    drain();
    doRead();
    chk("R7 after R9", rdData, 8'h3C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule